// File: doc/BRIEF.md
# Illegal video code remapper

This block sits in a 10-bit digital video data path and keeps picture samples from taking code values that are reserved for synchronisation. Each clock it takes one video word, an active-picture flag and a marker that tags timing-reference and ancillary-preamble words. Inside the active picture, samples in the top reserved band are pulled down to the highest legal code. Samples in the bottom reserved band are pushed up to the lowest legal code.

Words tagged by the marker may come from an 8-bit source. The block widens them to their 10-bit form, so that the downstream framing logic always sees full-width sync and preamble values. An active-high disable input turns the block into a plain one-cycle delay. All outputs are registered, and the flags are delayed alongside the word so that they stay aligned with it.

Top module: `vid_code_remap`

## Requirements
- R1: While `rst` is high at a clock edge, `out_word`, `out_act` and `out_mark` become zero.
- R2: Every output reflects the inputs sampled one clock edge earlier. `out_act` and `out_mark` equal `in_act` and `in_mark` from that edge.
- R3: With `dis` low, `in_act` high and `in_mark` low, an input code from 0x3FC to 0x3FF is output as 0x3FB.
- R4: With `dis` low, `in_act` high and `in_mark` low, an input code from 0x000 to 0x003 is output as 0x004.
- R5: With `dis` low, `in_act` high and `in_mark` low, an input code from 0x004 to 0x3FB is output unchanged.
- R6: With `dis` low and both `in_act` and `in_mark` low, every code is output unchanged, including the reserved ones.
- R7: With `dis` low and `in_mark` high, the 8-bit word carried in `in_word[9:2]` is widened. An 8-bit value of 0xFF gives 0x3FF. Any other value v gives {v, 2'b00}, so the low two input bits are ignored. This rule applies whatever the state of `in_act`.
- R8: With `dis` high, `in_word` is output unchanged whatever the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dis | input | 1 | High: pass words through unmodified |
| in_word | input | 10 | Incoming video word |
| in_act | input | 1 | Word lies inside the active picture |
| in_mark | input | 1 | Word is a TRS or ancillary preamble word (8-bit aligned to bit 9) |
| out_word | output | 10 | Remapped word, one cycle later |
| out_act | output | 1 | Delayed `in_act` |
| out_mark | output | 1 | Delayed `in_mark` |

## Verification
The bench drives every code at both edges of each reserved band, along with the legal neighbours 0x004 and 0x3FB. A comparison that is off by one either clamps a legal code or leaks a reserved one. Reserved codes are also sent with the active flag low and with the disable input high. A design that ignores the flag, or the disable input, clamps blanking data that must pass through untouched. Marked words are sent with non-zero low bits and with the active flag high. A design that keeps those low bits, or that lets the clamp override the widen path, turns 0x00 into 0x004 or 0xFF into 0x3FB. The words are streamed back to back, so a second pipeline stage or a flag left undelayed shows up as misalignment.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  // Which transformation the current word takes.
  typedef enum logic [1:0] {
    SEL_PASS  = 2'd0,
    SEL_CLAMP = 2'd1,
    SEL_WIDEN = 2'd2
  } vcr_sel_e;

  // Side-band flags carried along with each word.
  typedef struct packed {
    logic act;
    logic mark;
  } vcr_flags_t;
endpackage

// File: rtl/vcr_clamp.sv
// Pulls reserved codes at either end of the range onto the nearest legal code.
module vcr_clamp #(
  parameter int W = 10
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] TOP    = '1;
  localparam logic [W-1:0] HI_MIN = TOP - 3;
  localparam logic [W-1:0] HI_REP = TOP - 4;
  localparam logic [W-1:0] LO_MAX = 3;
  localparam logic [W-1:0] LO_REP = 4;

  always_comb begin
    if (din >= HI_MIN)      dout = HI_REP;
    else if (din <= LO_MAX) dout = LO_REP;
    else                    dout = din;
  end
endmodule

// File: rtl/vcr_widen.sv
// Expands a narrow sync or preamble word to full width.
module vcr_widen #(
  parameter int W  = 10,
  parameter int NW = 8
) (
  input  logic [NW-1:0] narrow,
  output logic [W-1:0]  wide
);
  localparam int PAD = W - NW;

  generate
    if (PAD == 0) begin : g_same
      assign wide = narrow;
    end else begin : g_pad
      always_comb begin
        if (&narrow) wide = '1;
        else         wide = {narrow, {PAD{1'b0}}};
      end
    end
  endgenerate
endmodule

// File: rtl/vid_code_remap.sv
module vid_code_remap #(
  parameter int W  = 10,
  parameter int NW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dis,
  input  logic [W-1:0] in_word,
  input  logic         in_act,
  input  logic         in_mark,
  output logic [W-1:0] out_word,
  output logic         out_act,
  output logic         out_mark
);
  import vcr_pkg::*;

  localparam logic [W-1:0] TOP    = '1;
  localparam logic [W-1:0] HI_MIN = TOP - 3;
  localparam logic [W-1:0] HI_REP = TOP - 4;
  localparam logic [W-1:0] LO_MAX = 3;
  localparam logic [W-1:0] LO_REP = 4;

  logic [W-1:0] clamped, widened, nxt_word;
  vcr_sel_e     sel;
  vcr_flags_t   flags_q;

  vcr_clamp #(.W(W)) u_clamp (.din(in_word), .dout(clamped));

  vcr_widen #(.W(W), .NW(NW)) u_widen (
    .narrow(in_word[W-1:W-NW]),
    .wide  (widened)
  );

  // The marker takes precedence over the active flag.
  always_comb begin
    if (dis)          sel = SEL_PASS;
    else if (in_mark) sel = SEL_WIDEN;
    else if (in_act)  sel = SEL_CLAMP;
    else              sel = SEL_PASS;
  end

  always_comb begin
    case (sel)
      SEL_CLAMP: nxt_word = clamped;
      SEL_WIDEN: nxt_word = widened;
      default:   nxt_word = in_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word <= '0;
      flags_q  <= '0;
    end else begin
      out_word <= nxt_word;
      flags_q  <= '{act: in_act, mark: in_mark};
    end
  end

  assign out_act  = flags_q.act;
  assign out_mark = flags_q.mark;

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (out_word == '0 && !out_act && !out_mark));

  // R2
  flag_delay_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_act == $past(in_act) && out_mark == $past(in_mark)));

  // R3
  hi_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (!dis && in_act && !in_mark && in_word >= HI_MIN) |=> out_word == HI_REP);

  // R4
  lo_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (!dis && in_act && !in_mark && in_word <= LO_MAX) |=> out_word == LO_REP);

  // R6
  blank_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!dis && !in_act && !in_mark) |=> out_word == $past(in_word));

  // R7
  widen_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (!dis && in_mark && (&in_word[W-1:W-NW])) |=> out_word == TOP);

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    dis |=> out_word == $past(in_word));
endmodule

// File: tb/tb_vid_code_remap.sv
module tb_vid_code_remap;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dis = 1'b0;
  logic [9:0] in_word = '0;
  logic       in_act = 1'b0;
  logic       in_mark = 1'b0;
  logic [9:0] out_word;
  logic       out_act, out_mark;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  bit         have_prev = 1'b0;
  logic [9:0] exp_word;
  logic       exp_act, exp_mark;
  string      exp_req;

  always #4 clk = ~clk;

  vid_code_remap dut (
    .clk(clk), .rst(rst), .dis(dis), .in_word(in_word),
    .in_act(in_act), .in_mark(in_mark),
    .out_word(out_word), .out_act(out_act), .out_mark(out_mark)
  );

  function automatic logic [9:0] model(logic [9:0] w, logic a, logic m, logic d);
    if (d) return w;
    if (m) return (w[9:2] == 8'hFF) ? 10'h3FF : {w[9:2], 2'b00};
    if (a) begin
      if (w >= 10'h3FC) return 10'h3FB;
      if (w <= 10'h003) return 10'h004;
    end
    return w;
  endfunction

  task automatic check(string req, logic [9:0] got, logic [9:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %03h expected %03h", req, got, exp);
    end
  endtask

  // One cycle: check the word registered from the previous input, then drive a new one.
  task automatic step(string req, logic [9:0] w, logic a, logic m, logic d);
    @(negedge clk);
    if (have_prev) begin
      check(exp_req, out_word, exp_word);
      check("R2 act", {9'd0, out_act}, {9'd0, exp_act});
      check("R2 mark", {9'd0, out_mark}, {9'd0, exp_mark});
    end
    in_word = w; in_act = a; in_mark = m; dis = d;
    exp_word = model(w, a, m, d); exp_act = a; exp_mark = m; exp_req = req;
    have_prev = 1'b1;
  endtask

  task automatic flush();
    step("R6 idle", 10'h000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    in_word = 10'h2AA; in_act = 1'b1; in_mark = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 word", out_word, 10'h000);
    check("R1 flags", {8'd0, out_act, out_mark}, 10'h000);
    rst = 1'b0;
    have_prev = 1'b0;
  endtask

  task automatic t_hi_clamp();
    for (int c = 'h3FC; c <= 'h3FF; c++) step("R3", 10'(c), 1'b1, 1'b0, 1'b0);
    flush();
  endtask

  task automatic t_lo_clamp();
    for (int c = 0; c <= 3; c++) step("R4", 10'(c), 1'b1, 1'b0, 1'b0);
    flush();
  endtask

  task automatic t_legal_active();
    step("R5", 10'h004, 1'b1, 1'b0, 1'b0);
    step("R5", 10'h3FB, 1'b1, 1'b0, 1'b0);
    step("R5", 10'h200, 1'b1, 1'b0, 1'b0);
    step("R5", 10'h155, 1'b1, 1'b0, 1'b0);
    flush();
  endtask

  task automatic t_blanking();
    step("R6", 10'h3FF, 1'b0, 1'b0, 1'b0);
    step("R6", 10'h000, 1'b0, 1'b0, 1'b0);
    step("R6", 10'h3FD, 1'b0, 1'b0, 1'b0);
    step("R6", 10'h002, 1'b0, 1'b0, 1'b0);
    flush();
  endtask

  task automatic t_widen();
    step("R7", {8'hFF, 2'b00}, 1'b0, 1'b1, 1'b0);
    step("R7", {8'h00, 2'b11}, 1'b0, 1'b1, 1'b0);
    step("R7", {8'h00, 2'b01}, 1'b1, 1'b1, 1'b0);
    step("R7", {8'hFF, 2'b00}, 1'b1, 1'b1, 1'b0);
    step("R7", {8'h9D, 2'b11}, 1'b0, 1'b1, 1'b0);
    flush();
  endtask

  task automatic t_bypass();
    step("R8", 10'h3FE, 1'b1, 1'b0, 1'b1);
    step("R8", 10'h001, 1'b1, 1'b0, 1'b1);
    step("R8", {8'h00, 2'b11}, 1'b0, 1'b1, 1'b1);
    step("R8", {8'hFF, 2'b00}, 1'b1, 1'b1, 1'b1);
    flush();
  endtask

  task automatic t_stream();
    for (int i = 0; i < 64; i++)
      step("R2 stream", 10'((i * 97 + 1000) % 1024), 1'(i % 3 != 0), 1'(i % 7 == 0), 1'(i % 11 == 0));
    flush();
  endtask

  initial begin
    t_reset();
    t_hi_clamp();
    t_lo_clamp();
    t_legal_active();
    t_blanking();
    t_widen();
    t_bypass();
    t_stream();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule